// File: doc/BRIEF.md
# Receive Message FIFO with Boundary Accounting

This block buffers received bytes between a serial-link packet receiver and a host. The receiver writes one byte per cycle, tagging bytes that start or end a message; an end marker carries a two-bit completion code. The host pops bytes one at a time from a show-ahead output. It uses a byte count that never runs past the end of the oldest message still in the buffer, so the host always knows how much it can drain before it must read that message's completion code.

Bit 7 of the count output says whether the chunk on offer is still open: the chunk is a first part or a continuation, and no completion code follows it. When bit 7 is clear and the count is non-zero, the chunk closes a message. That message is either whole or the tail of one already partly drained. Popping its final byte publishes its completion code. A real-time fill flag compares occupancy against a programmable threshold. When the receiver outruns the host, the buffer is emptied, the rest of the message being received is thrown away, and an overrun pulse is raised.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset the count output is 0 with bit 7 clear, and `hwm_o`, `ovr_o` and `msg_done_o` are low.
- R2: Bytes leave in write order. `rd_data_o` shows the oldest byte, each `rd_pop_i` removes one, and a pop with nothing held has no effect.
- R3: With no complete message held, `avail_o[6:0]` equals the number of bytes held. Bit 7 is 1 whenever that number is non-zero.
- R4: With at least one complete message held, `avail_o[6:0]` counts the bytes up to and including the oldest message's last byte. Bit 7 is 0 in that case, whatever is queued behind.
- R5: `avail_o` reflects a push or pop from the cycle after it. A push and a pop in the same cycle leave the count unchanged.
- R6: Popping a message's last byte gives a one-cycle `msg_done_o` pulse on the next cycle. `msg_stat_o` then holds that message's code (00 good, 01 abort, 10 CRC error) until the next message completes.
- R7: `hwm_o` is high exactly while occupancy exceeds `wm_i`. It follows `wm_i` changes in the same cycle.
- R8: A write accepted while 64 bytes are held empties the buffer, and `ovr_o` pulses high for one cycle on the next cycle. The count output reads 0 from that cycle on. Later bytes of that message are discarded up to and including its end byte, unless a start-tagged byte arrives first; that byte is stored.
- R9: An end-tagged write while 8 completed messages are held is an overrun as in R8. Because the message ended, the next byte is stored even without a start tag.
- R10: Exactly 64 bytes can be held, and the count output then reads 64 (0xC0 with an open message).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Receiver byte strobe |
| wr_data_i | input | 8 | Received byte |
| wr_sop_i | input | 1 | Byte starts a message |
| wr_eop_i | input | 1 | Byte ends a message |
| wr_stat_i | input | 2 | Completion code, used with the end tag |
| rd_pop_i | input | 1 | Host removes one byte |
| rd_data_o | output | 8 | Oldest held byte |
| avail_o | output | 8 | [6:0] readable count, [7] chunk still open |
| wm_i | input | 6 | High-watermark threshold |
| hwm_o | output | 1 | Occupancy above threshold |
| ovr_o | output | 1 | Overrun pulse |
| msg_done_o | output | 1 | Message fully drained pulse |
| msg_stat_o | output | 2 | Completion code of last drained message |

## Verification
The bench uses the default parameters: 64 byte slots and an 8-entry end-of-message queue. At these sizes the bench can fill the byte store to its last slot in 64 writes and the message queue with 8 one-byte messages. That makes both overrun causes, the discard that follows, and the count at its 64 ceiling reachable within a short directed run. The watermark at 63 against a full buffer covers the top of the comparator range.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef enum logic [1:0] {
    MSG_GOOD  = 2'b00,
    MSG_ABORT = 2'b01,
    MSG_CRC   = 2'b10
  } msg_stat_e;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxf_eom_q.sv
module rxf_eom_q
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = 7,
  localparam int QAW  = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_end_i,
  input  msg_stat_e     push_stat_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic          full_o,
  output logic [PW-1:0] head_end_o,
  output msg_stat_e     head_stat_o
);
  typedef struct packed {
    logic [PW-1:0] end_ptr;
    msg_stat_e     stat;
  } eom_t;

  eom_t           ent_q [DEPTH];
  logic [QAW-1:0] wr_q, rd_q;
  logic [QAW:0]   cnt_q;

  assign valid_o     = cnt_q != '0;
  assign full_o      = cnt_q == (QAW+1)'(DEPTH);
  assign head_end_o  = ent_q[rd_q].end_ptr;
  assign head_stat_o = ent_q[rd_q].stat;

  always_ff @(posedge clk_i) begin
    if (push_i) ent_q[wr_q] <= '{end_ptr: push_end_i, stat: push_stat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == QAW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == QAW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (QAW+1)'(push_i) - (QAW+1)'(pop_i);
    end
  end

  a_r9_no_q_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < (QAW+1)'(DEPTH));
  a_r6_no_q_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int EOM_DEPTH = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_valid_i,
  input  logic [7:0]   wr_data_i,
  input  logic         wr_sop_i,
  input  logic         wr_eop_i,
  input  logic [1:0]   wr_stat_i,
  input  logic         rd_pop_i,
  output logic [7:0]   rd_data_o,
  output logic [7:0]   avail_o,
  input  logic [AW-1:0] wm_i,
  output logic         hwm_o,
  output logic         ovr_o,
  output logic         msg_done_o,
  output logic [1:0]   msg_stat_o
);
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, occ;
  logic          drop_q, ovr_q, done_q;
  msg_stat_e     stat_q;
  logic          full, take, overrun, push, pop;
  logic          eq_valid, eq_full, eq_pop;
  logic [PW-1:0] eq_end;
  msg_stat_e     eq_stat;

  assign occ  = wr_ptr_q - rd_ptr_q;
  assign full = occ == PW'(DEPTH);
  // while discarding a dead message, only a start-tagged byte is taken
  assign take    = wr_valid_i && (!drop_q || wr_sop_i);
  assign overrun = take && (full || (wr_eop_i && eq_full));
  assign push    = take && !overrun;
  assign pop     = rd_pop_i && (occ != '0) && !overrun;
  assign eq_pop  = pop && eq_valid && (rd_ptr_q + 1'b1 == eq_end);

  rxf_mem #(.DEPTH(DEPTH), .W(8)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wr_ptr_q[AW-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr_q[AW-1:0]),
    .rdata_o (rd_data_o)
  );

  rxf_eom_q #(.DEPTH(EOM_DEPTH), .PW(PW)) u_eom_q (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (overrun),
    .push_i      (push && wr_eop_i),
    .push_end_i  (wr_ptr_q + 1'b1),
    .push_stat_i (msg_stat_e'(wr_stat_i)),
    .pop_i       (eq_pop),
    .valid_o     (eq_valid),
    .full_o      (eq_full),
    .head_end_o  (eq_end),
    .head_stat_o (eq_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      drop_q   <= 1'b0;
      ovr_q    <= 1'b0;
      done_q   <= 1'b0;
      stat_q   <= MSG_GOOD;
    end else begin
      ovr_q  <= overrun;
      done_q <= eq_pop;
      if (eq_pop) stat_q <= eq_stat;
      if (overrun) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        drop_q   <= !wr_eop_i;
      end else begin
        if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
        if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
        if (wr_valid_i && (wr_sop_i || wr_eop_i)) drop_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (eq_valid) avail_o = {1'b0, 7'(eq_end - rd_ptr_q)};
    else          avail_o = {occ != '0, 7'(occ)};
  end

  assign hwm_o      = occ > PW'(wm_i);
  assign ovr_o      = ovr_q;
  assign msg_done_o = done_q;
  assign msg_stat_o = stat_q;

  a_r8_empty_after_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (avail_o == 8'h00 && !hwm_o));
  a_r4_chunk_within_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(avail_o[6:0]) <= occ);
  a_r10_avail_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o[6:0] <= 7'(DEPTH));
  a_r6_done_follows_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_done_o |-> $past(rd_pop_i));
  a_r2_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> !full);
endmodule

// File: tb/rx_msg_fifo_bench.sv
`timescale 1ns/1ps
module rx_msg_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_pop = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] wr_stat = 2'b00;
  logic [5:0] wm = 6'd0;
  logic [7:0] rd_data, avail;
  logic       hwm, ovr, done;
  logic [1:0] mstat;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rx_msg_fifo u_rx_msg_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_sop_i(wr_sop), .wr_eop_i(wr_eop), .wr_stat_i(wr_stat), .rd_pop_i(rd_pop),
    .rd_data_o(rd_data), .avail_o(avail), .wm_i(wm), .hwm_o(hwm), .ovr_o(ovr),
    .msg_done_o(done), .msg_stat_o(mstat)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_stat = 0; rd_pop = 0;
  endtask

  task automatic wr(input logic [7:0] d, input logic s, input logic e, input logic [1:0] st);
    wr_valid = 1; wr_data = d; wr_sop = s; wr_eop = e; wr_stat = st;
    step();
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    chk(req, rd_data, exp);
    rd_pop = 1;
    step();
  endtask

  task automatic do_reset();
    rst_n = 0; wm = 0;
    #7; rst_n = 1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 avail", avail, 8'h00);
    chk("R1 flags", {hwm, ovr, done}, 3'b000);
  endtask

  task automatic t_open();
    do_reset();
    wm = 6'd2;
    wr(8'h00, 1, 0, 0); wr(8'h01, 0, 0, 0); wr(8'h02, 0, 0, 0);
    chk("R3 open count", avail, 8'h83);
    chk("R7 above wm", hwm, 1);
    wm = 6'd3; #1;
    chk("R7 at wm", hwm, 0);
    // simultaneous push and pop
    chk("R2 head", rd_data, 8'h00);
    wr_valid = 1; wr_data = 8'h03; rd_pop = 1;
    step();
    chk("R5 push+pop", avail, 8'h83);
    chk("R2 next head", rd_data, 8'h01);
  endtask

  task automatic t_boundary();
    do_reset();
    for (int i = 0; i < 5; i++) wr(8'h10 + 8'(i), i == 0, i == 4, 2'b00);
    wr(8'h20, 1, 0, 0); wr(8'h21, 0, 1, 2'b10);
    wr(8'h30, 1, 0, 0); wr(8'h31, 0, 0, 0); wr(8'h32, 0, 0, 0);
    chk("R4 first msg", avail, 8'h05);
    for (int i = 0; i < 5; i++) rd("R2 msg A data", 8'h10 + 8'(i));
    chk("R6 done good", {done, mstat}, 3'b100);
    chk("R4 second msg", avail, 8'h02);
    rd("R2 msg B data", 8'h20);
    chk("R6 done low", done, 0);
    chk("R5 after pop", avail, 8'h01);
    rd("R2 msg B data", 8'h21);
    chk("R6 done crc", {done, mstat}, 3'b110);
    chk("R3 tail open", avail, 8'h83);
    wr(8'h33, 0, 1, 2'b01);
    chk("R4 last part", avail, 8'h04);
    for (int i = 0; i < 4; i++) rd("R2 msg C data", 8'h30 + 8'(i));
    chk("R6 done abort", {done, mstat}, 3'b101);
    chk("R1 drained", avail, 8'h00);
  endtask

  task automatic t_empty_pop();
    do_reset();
    rd_pop = 1; step();
    chk("R2 pop empty", avail, 8'h00);
    wr(8'h5A, 1, 0, 0);
    chk("R2 after empty pop", {avail, rd_data}, 16'h815A);
  endtask

  task automatic t_full();
    do_reset();
    wm = 6'd63;
    for (int i = 0; i < 64; i++) wr(8'(i), i == 0, 0, 0);
    chk("R10 full count", avail, 8'hC0);
    chk("R7 full hwm", hwm, 1);
    chk("R10 no ovr", ovr, 0);
    wr(8'hEE, 0, 0, 0);
    chk("R8 ovr pulse", ovr, 1);
    chk("R8 flushed", avail, 8'h00);
    wr(8'hE1, 0, 0, 0);
    chk("R8 ovr one cycle", ovr, 0);
    chk("R8 drop mid", avail, 8'h00);
    wr(8'hE2, 0, 1, 0);
    chk("R8 drop end", avail, 8'h00);
    wr(8'h77, 1, 0, 0);
    chk("R8 new msg kept", {avail, rd_data}, 16'h8177);
  endtask

  task automatic t_eom_full();
    do_reset();
    for (int i = 0; i < 8; i++) wr(8'h40 + 8'(i), 1, 1, 0);
    chk("R4 one-byte msgs", avail, 8'h01);
    wr(8'h48, 1, 1, 0);
    chk("R9 ovr pulse", ovr, 1);
    chk("R9 flushed", avail, 8'h00);
    wr(8'h44, 0, 0, 0);
    chk("R9 no drop", {avail, rd_data}, 16'h8144);
  endtask

  initial begin
    t_reset();
    t_open();
    t_boundary();
    t_empty_pop();
    t_full();
    t_eom_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule